// File: doc/BRIEF.md
# Packed Integer SIMD Execution Unit

This block executes packed integer operations on 64-bit words held in a local file of eight registers. One operation can be accepted per clock. An operation is an opcode, two register indices (`srcA`, `srcB`) and a valid strobe. A condition flag is sampled together with the operation. There are five operations:

- byte-lane add that wraps around;
- signed saturating add on 16-bit lanes;
- the same saturating add with an implied destination;
- exchange of the two 32-bit halves of a word;
- move gated by the condition flag.

The result is captured in a single result stage and written to the register file on the next edge. A done strobe is high during the cycle between those two edges. Operands are forwarded from the result stage, so dependent operations can be issued back to back.

A separate load port writes registers directly. A combinational read port shows any register, so a testbench or a neighbouring block can preload operands and inspect results.

Top module: `simd_exec_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all eight registers to zero and holds `opDone` low.
- R2: Opcode 0 writes to register `srcA` the lane-wise sum of `srcA` and `srcB` taken as eight 8-bit lanes, each modulo 256, with no carry between lanes.
- R3: Opcode 1 writes to register `srcA` the lane-wise sum of `srcA` and `srcB` taken as four signed 16-bit lanes (lane i in bits 16i+15..16i), each clamped to -32768..32767.
- R4: Opcode 2 computes the same saturating sum as R3 but writes it to register `srcA` XOR 1. Registers `srcA` and `srcB` are not written, unless one of them is the target.
- R5: Opcode 3 writes to register `srcA` the value of register `srcB` with bits 63..32 and 31..0 exchanged.
- R6: Opcode 4 copies register `srcB` into register `srcA` when `condFlag` is 1. When `condFlag` is 0 it writes nothing and `srcA` keeps its value.
- R7: Opcodes 0 to 3 give the same result whatever the value of `condFlag`.
- R8: For an operation accepted at edge k (`opValid` high, opcode 0 to 4), `opDone` is high for exactly the cycle between edges k and k+1. The register is updated at edge k+1 and `rdData` shows the new value after it. Opcodes 5 to 7 write nothing and raise no `opDone`.
- R9: An operation accepted at edge k+1 that reads the register being written back at that edge uses the new value.
- R10: With `wrEn` high at an edge, register `wrIdx` takes `wrData`. If an operation writeback targets the same register at the same edge, the writeback value wins. `rdData` always shows register `rdIdx` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation select (0 to 4 defined) |
| srcA | input | 3 | First operand and destination index |
| srcB | input | 3 | Second operand index |
| condFlag | input | 1 | Condition for the gated move |
| wrEn | input | 1 | Load-port write enable |
| wrIdx | input | 3 | Load-port register index |
| wrData | input | 64 | Load-port data |
| rdIdx | input | 3 | Read-port register index |
| rdData | output | 64 | Read-port data |
| opDone | output | 1 | Result writeback strobe |

## Verification
A wrong lane boundary or a wrong clamp shows up in `rdData` of the target register one edge after `opDone`. That is two edges after the operation is issued. A wrong implied target leaves the expected register stale and corrupts the neighbour in the same cycle. A broken bypass does not show until a dependent operation lands one edge later, so back-to-back chains are driven on purpose. A lost or late writeback shows as a register that does not match the model on its very next read.

// File: rtl/simd_pkg.sv
package simd_pkg;
  parameter int DATA_W  = 64;
  parameter int REG_CNT = 8;
  parameter int BYTE_W  = 8;
  parameter int HALF_W  = 16;
  localparam int IDX_W  = $clog2(REG_CNT);

  localparam logic [2:0] OPC_ADD_WRAP  = 3'd0;
  localparam logic [2:0] OPC_ADD_SAT   = 3'd1;
  localparam logic [2:0] OPC_ADD_SATX  = 3'd2;
  localparam logic [2:0] OPC_SWAP_HALF = 3'd3;
  localparam logic [2:0] OPC_COND_MOVE = 3'd4;

  typedef enum logic [1:0] {
    RES_WRAP = 2'd0,
    RES_SAT  = 2'd1,
    RES_SWAP = 2'd2,
    RES_MOVE = 2'd3
  } resSel_e;

  typedef struct packed {
    logic             accept;
    logic             writeEn;
    resSel_e          sel;
    logic [IDX_W-1:0] dest;
  } ctrlStrobes_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic [IDX_W-1:0] srcA,
  input  logic             condFlag,
  output ctrlStrobes_t     ctrl
);
  logic known;

  always_comb begin
    known        = 1'b1;
    ctrl.sel     = RES_WRAP;
    ctrl.dest    = srcA;
    ctrl.writeEn = 1'b1;
    case (opCode)
      OPC_ADD_WRAP:  ctrl.sel = RES_WRAP;
      OPC_ADD_SAT:   ctrl.sel = RES_SAT;
      OPC_ADD_SATX: begin
        ctrl.sel  = RES_SAT;
        ctrl.dest = srcA ^ IDX_W'(1);
      end
      OPC_SWAP_HALF: ctrl.sel = RES_SWAP;
      OPC_COND_MOVE: begin
        ctrl.sel     = RES_MOVE;
        ctrl.writeEn = condFlag;
      end
      default: begin
        known        = 1'b0;
        ctrl.writeEn = 1'b0;
      end
    endcase
    ctrl.accept = opValid && known;
    if (!ctrl.accept) ctrl.writeEn = 1'b0;
  end

  // R4: implied target is the partner register
  a_r4_implied_dest: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == OPC_ADD_SATX) |-> (ctrl.dest != srcA && ctrl.writeEn));

  // R6: gated move with clear flag never writes
  a_r6_move_gated: assert property (@(posedge clk) disable iff (rst)
    (opCode == OPC_COND_MOVE && !condFlag) |-> !ctrl.writeEn);

  // R8: undefined opcodes are never accepted
  a_r8_undefined_quiet: assert property (@(posedge clk) disable iff (rst)
    (opCode > OPC_COND_MOVE) |-> !ctrl.accept);
endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NREG = REG_CNT,
  parameter int BW   = BYTE_W,
  parameter int HW   = HALF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     ctrl,
  input  logic [IDX_W-1:0] srcA,
  input  logic [IDX_W-1:0] srcB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [DW-1:0]    wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [DW-1:0]    rdData,
  output logic             opDone
);
  localparam int BYTE_LANES = DW / BW;
  localparam int HALF_LANES = DW / HW;
  localparam int SPLIT      = DW / 2;

  logic [DW-1:0]    regFile [NREG];
  logic             stgValid, stgWrite;
  logic [IDX_W-1:0] stgDest;
  logic [DW-1:0]    stgData;
  logic [DW-1:0]    opA, opB, wrapSum, satSum, swapVal, result;
  logic             fwdA, fwdB;

  // operand bypass from the result stage
  assign fwdA = stgValid && stgWrite && (stgDest == srcA);
  assign fwdB = stgValid && stgWrite && (stgDest == srcB);
  assign opA  = fwdA ? stgData : regFile[srcA];
  assign opB  = fwdB ? stgData : regFile[srcB];

  for (genvar i = 0; i < BYTE_LANES; i++) begin : g_wrap
    assign wrapSum[i*BW +: BW] = opA[i*BW +: BW] + opB[i*BW +: BW];
  end

  for (genvar j = 0; j < HALF_LANES; j++) begin : g_sat
    logic [HW:0] wide;
    assign wide = {opA[j*HW+HW-1], opA[j*HW +: HW]} + {opB[j*HW+HW-1], opB[j*HW +: HW]};
    always_comb begin
      if (wide[HW] != wide[HW-1])
        satSum[j*HW +: HW] = wide[HW] ? {1'b1, {(HW-1){1'b0}}} : {1'b0, {(HW-1){1'b1}}};
      else
        satSum[j*HW +: HW] = wide[HW-1:0];
    end
  end

  assign swapVal = {opB[SPLIT-1:0], opB[DW-1:SPLIT]};

  always_comb begin
    case (ctrl.sel)
      RES_WRAP: result = wrapSum;
      RES_SAT:  result = satSum;
      RES_SWAP: result = swapVal;
      default:  result = opB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stgValid <= 1'b0;
      stgWrite <= 1'b0;
      stgDest  <= '0;
      stgData  <= '0;
    end else begin
      stgValid <= ctrl.accept;
      stgWrite <= ctrl.writeEn;
      stgDest  <= ctrl.dest;
      stgData  <= result;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) regFile[r] <= '0;
    end else begin
      if (wrEn) regFile[wrIdx] <= wrData;
      if (stgValid && stgWrite) regFile[stgDest] <= stgData;
    end
  end

  assign rdData = regFile[rdIdx];
  assign opDone = stgValid;

  // R8: done only follows an accepted operation
  a_r8_done_follows: assert property (@(posedge clk) disable iff (rst)
    opDone |-> $past(ctrl.accept));

  // R10: a pending writeback always lands, ahead of the load port
  a_r10_writeback_lands: assert property (@(posedge clk) disable iff (rst)
    (stgValid && stgWrite) |=> (regFile[$past(stgDest)] == $past(stgData)));
endmodule

// File: rtl/simd_exec_unit.sv
module simd_exec_unit
  import simd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [IDX_W-1:0]  srcA,
  input  logic [IDX_W-1:0]  srcB,
  input  logic              condFlag,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              opDone
);
  ctrlStrobes_t ctrl;

  simd_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opValid  (opValid),
    .opCode   (opCode),
    .srcA     (srcA),
    .condFlag (condFlag),
    .ctrl     (ctrl)
  );

  simd_datapath #(
    .DW   (DATA_W),
    .NREG (REG_CNT),
    .BW   (BYTE_W),
    .HW   (HALF_W)
  ) i_datapath (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .rdIdx  (rdIdx),
    .rdData (rdData),
    .opDone (opDone)
  );
endmodule

// File: tb/test_simd_exec_unit.sv
`timescale 1ns/1ps
module test_simd_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [2:0]  srcA = '0;
  logic [2:0]  srcB = '0;
  logic        condFlag = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic [2:0]  rdIdx = '0;
  logic [63:0] rdData;
  logic        opDone;

  int unsigned nChecks = 0;
  int unsigned nFails  = 0;
  logic [63:0] model [8];

  always #2.5 clk = ~clk;

  simd_exec_unit i_simd_exec_unit (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .condFlag(condFlag),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .opDone(opDone)
  );

  function automatic logic [63:0] refWrap(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = 8'((int'(a[i*8 +: 8]) + int'(b[i*8 +: 8])) % 256);
    return r;
  endfunction

  function automatic logic [63:0] refSat(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    for (int i = 0; i < 4; i++) begin
      int s;
      s = int'($signed(a[i*16 +: 16])) + int'($signed(b[i*16 +: 16]));
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      r[i*16 +: 16] = 16'(s);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readCheck(input string req, input logic [2:0] idx);
    rdIdx = idx;
    #1;
    check(req, rdData, model[idx]);
  endtask

  task automatic loadReg(input logic [2:0] idx, input logic [63:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
    model[idx] = val;
  endtask

  // one operation, checked for done timing and the target value
  task automatic runOp(input string req, input logic [2:0] op, input logic [2:0] a,
                       input logic [2:0] b, input logic flag);
    logic [2:0]  dest;
    logic        writes;
    logic [63:0] val;
    dest = a; writes = 1'b1; val = '0;
    case (op)
      3'd0: val = refWrap(model[a], model[b]);
      3'd1: val = refSat(model[a], model[b]);
      3'd2: begin val = refSat(model[a], model[b]); dest = a ^ 3'd1; end
      3'd3: val = {model[b][31:0], model[b][63:32]};
      3'd4: begin val = model[b]; writes = flag; end
      default: writes = 1'b0;
    endcase
    @(negedge clk);
    opValid = 1'b1; opCode = op; srcA = a; srcB = b; condFlag = flag;
    @(negedge clk);
    opValid = 1'b0; condFlag = ~flag;
    check("R8 done pulse", 64'(opDone), 64'(op <= 3'd4));
    if (writes) model[dest] = val;
    @(negedge clk);
    check("R8 done single", 64'(opDone), 64'd0);
    readCheck(req, dest);
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done low", 64'(opDone), 64'd0);
    for (int r = 0; r < 8; r++) readCheck("R1 reset clear", 3'(r));

    // R10: load port and combinational read
    for (int r = 0; r < 8; r++) begin
      loadReg(3'(r), {$urandom, $urandom});
      readCheck("R10 load", 3'(r));
    end

    // R2: carries stay inside their byte lanes
    loadReg(3'd0, 64'hFF80_7F01_FFFF_00FF);
    loadReg(3'd1, 64'h0180_0101_0101_0001);
    runOp("R2 lane wrap", 3'd0, 3'd0, 3'd1, 1'b0);

    // R3: both clamp directions and a non-clamped lane
    loadReg(3'd2, 64'h7FFF_8000_1234_FFFF);
    loadReg(3'd3, 64'h0001_FFFF_0001_8000);
    runOp("R3 sat clamp", 3'd1, 3'd2, 3'd3, 1'b1);

    // R4: implied destination partner register
    loadReg(3'd5, 64'h7000_9000_0002_0003);
    loadReg(3'd6, 64'h2000_9000_0004_0005);
    runOp("R4 implied dest", 3'd2, 3'd5, 3'd6, 1'b0);
    readCheck("R4 srcA untouched", 3'd5);
    readCheck("R4 srcB untouched", 3'd6);

    // R5: half exchange
    loadReg(3'd7, 64'hAAAA_BBBB_CCCC_DDDD);
    runOp("R5 half swap", 3'd3, 3'd1, 3'd7, 1'b0);

    // R6: gated move both ways
    loadReg(3'd4, 64'h0123_4567_89AB_CDEF);
    runOp("R6 move flag clear", 3'd4, 3'd3, 3'd4, 1'b0);
    runOp("R6 move flag set", 3'd4, 3'd3, 3'd4, 1'b1);

    // R7: flag has no influence on the adds and swap
    runOp("R7 wrap flag set", 3'd0, 3'd6, 3'd4, 1'b1);
    runOp("R7 swap flag set", 3'd3, 3'd2, 3'd6, 1'b1);

    // R8: undefined opcode is a no-op
    runOp("R8 undefined op", 3'd6, 3'd0, 3'd1, 1'b1);

    // R9: back-to-back dependency through the bypass
    begin
      logic [63:0] first, second;
      first  = refWrap(model[0], model[1]);
      second = refSat(model[2], first);
      @(negedge clk);
      opValid = 1'b1; opCode = 3'd0; srcA = 3'd0; srcB = 3'd1;
      @(negedge clk);
      opCode = 3'd1; srcA = 3'd2; srcB = 3'd0;
      @(negedge clk);
      opValid = 1'b0;
      @(negedge clk);
      model[0] = first; model[2] = second;
      readCheck("R9 forward producer", 3'd0);
      readCheck("R9 forward consumer", 3'd2);
    end

    // R10: writeback beats the load port on the same edge
    begin
      logic [63:0] sum;
      sum = refWrap(model[3], model[4]);
      @(negedge clk);
      opValid = 1'b1; opCode = 3'd0; srcA = 3'd3; srcB = 3'd4;
      @(negedge clk);
      opValid = 1'b0;
      wrEn = 1'b1; wrIdx = 3'd3; wrData = 64'hDEAD_BEEF_DEAD_BEEF;
      @(negedge clk);
      wrEn = 1'b0;
      model[3] = sum;
      readCheck("R10 collision", 3'd3);
    end

    // random mix, including saturation-prone operands
    for (int n = 0; n < 300; n++) begin
      logic [2:0] op;
      if ($urandom_range(0, 3) == 0) begin
        logic [63:0] v;
        v = {$urandom, $urandom};
        if ($urandom_range(0, 1) == 1) v = v | 64'h7000_7000_7000_7000;
        loadReg(3'($urandom_range(0, 7)), v);
      end
      op = 3'($urandom_range(0, 7));
      case (op)
        3'd0: runOp("R2 random", op, 3'($urandom), 3'($urandom), 1'($urandom));
        3'd1: runOp("R3 random", op, 3'($urandom), 3'($urandom), 1'($urandom));
        3'd2: runOp("R4 random", op, 3'($urandom), 3'($urandom), 1'($urandom));
        3'd3: runOp("R5 random", op, 3'($urandom), 3'($urandom), 1'($urandom));
        3'd4: runOp("R6 random", op, 3'($urandom), 3'($urandom), 1'($urandom));
        default: runOp("R8 random", op, 3'($urandom), 3'($urandom), 1'($urandom));
      endcase
    end
    for (int r = 0; r < 8; r++) readCheck("R10 final", 3'(r));

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule